// File: doc/BRIEF.md
# Halfword-Fed Word Buffer with Sequential Playback

This block loads a fixed number of data words from external memory into an on-chip buffer, then hands them to a consumer one at a time. A loader asks for a reload by raising a request line together with a base byte address. The block then fetches 16-bit halfwords from a memory read port, one at a time. Each fetch uses a request/acknowledge handshake whose latency is not known in advance. The block joins each pair of halfwords into one 20-bit word and writes it into the buffer. When the buffer is full it raises a done flag and holds it until the loader withdraws the request.

The consumer side shows the current word together with a valid flag and a final-word flag. A single-cycle step pulse moves to the next word. A rewind pulse goes back to word zero. The consumer side reports nothing valid while a reload is running. Step and rewind pulses are ignored during that time.

The load controller has these states:
- `F_IDLE`: idle.
- `F_LO_REQ`: fetching the low halfword.
- `F_LO_REL`: releasing the low fetch.
- `F_HI_REQ`: fetching the high halfword.
- `F_HI_REL`: releasing the high fetch.
- `F_DONE`: buffer full, waiting for the request to drop.

Its transitions are:
- idle→lo-req on request.
- req→rel on acknowledge.
- rel→next req when the acknowledge clears.
- hi-rel→done after the last word.
- done→idle when the request drops.

The playback side has three states, `R_EMPTY`, `R_FILL` and `R_SERVE`. Its transitions are:
- empty→fill and serve→fill when loading starts.
- fill→serve when the done flag is seen.

Top module: `halfword_fill_buffer`

## Requirements
- R1: After reset `mem_rd`, `fill_done`, `rd_valid` and `rd_final` are all low.
- R2: A reload reads halfwords at consecutive byte addresses A, A+2, A+4, and so on. A is `fill_base` with its two low bits forced to zero. `mem_addr` stays stable while `mem_rd` is high.
- R3: `mem_rd` stays high until `mem_ack` is seen, then drops in the next cycle. A new request is raised only after `mem_ack` has returned low.
- R4: Buffered word i has bits [15:0] taken from the halfword at A+4i. Its bits [19:16] are taken from bits [3:0] of the halfword at A+4i+2. Bits [15:4] of that second halfword are discarded.
- R5: `fill_done` rises once DEPTH words are stored. It stays high while `fill_req` is high and falls in the cycle after `fill_req` drops.
- R6: `rd_valid` is low during a reload. `rd_step` and `rd_rewind` pulses given during a reload have no effect, so playback starts at word 0.
- R7: After a reload the output presents word 0. Each `rd_step` pulse advances the output by one word, visible in the cycle after the pulse.
- R8: `rd_final` is high exactly when word DEPTH-1 is presented. A step given there leaves the output unchanged.
- R9: `rd_rewind` returns the output to word 0 and takes priority over a simultaneous `rd_step`.
- R10: Every read address lies in the range [A, A+4·DEPTH) and is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_req | input | 1 | Reload request, held until `fill_done` rises |
| fill_base | input | ADDR_W | Byte address of the first halfword |
| fill_done | output | 1 | Buffer full; falls after the request drops |
| mem_addr | output | ADDR_W | Halfword read address |
| mem_rd | output | 1 | Read request, held until acknowledged |
| mem_ack | input | 1 | Read acknowledge; low again once `mem_rd` is low |
| mem_data | input | HALF_W | Halfword returned with `mem_ack` |
| rd_step | input | 1 | Advance to the next word |
| rd_rewind | input | 1 | Return to word 0 |
| rd_data | output | WORD_W | Current word |
| rd_valid | output | 1 | `rd_data` holds a buffered word |
| rd_final | output | 1 | Current word is the last one |

## Verification
The bound checker checks the memory handshake on every cycle: the request is held, it drops after acknowledge, it never restarts while acknowledge is still high, and the address is stable and even. It also checks on every cycle that the done flag holds and releases with the request, that nothing valid is shown during a fetch, and that the final flag is sticky under step. The bench scenarios are needed for what depends on data and on sequence: address order and range against the base, how the halfwords are joined and their upper bits dropped, playback order through the vector table, rewind priority, and pulses ignored during a reload.

// File: rtl/hfb_pkg.sv
package hfb_pkg;

    typedef enum logic [2:0] {
        F_IDLE,
        F_LO_REQ,
        F_LO_REL,
        F_HI_REQ,
        F_HI_REL,
        F_DONE
    } fill_state_t;

    typedef enum logic [1:0] {
        R_EMPTY,
        R_FILL,
        R_SERVE
    } play_state_t;

endpackage

// File: rtl/hfb_fill_ctrl.sv
module hfb_fill_ctrl
    import hfb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HALF_W = 16,
    parameter int WORD_W = 20,
    parameter int DEPTH  = 2047,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_req,
    input  logic [ADDR_W-1:0] fill_base,
    input  logic              mem_ack,
    input  logic [HALF_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              fill_done,
    output logic              filling,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data
);

    localparam int HI_KEEP = WORD_W - HALF_W;
    localparam logic [IDX_W-1:0]  LAST  = IDX_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(3);

    fill_state_t       st_q, st_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [HALF_W-1:0] lo_q;

    // next state and datapath
    always_comb begin
        st_d   = st_q;
        addr_d = addr_q;
        idx_d  = idx_q;
        unique case (st_q)
            F_IDLE: begin
                if (fill_req) begin
                    st_d   = F_LO_REQ;
                    addr_d = fill_base & ALIGN;
                    idx_d  = '0;
                end
            end
            F_LO_REQ: begin
                if (mem_ack) st_d = F_LO_REL;
            end
            F_LO_REL: begin
                if (!mem_ack) begin
                    st_d   = F_HI_REQ;
                    addr_d = addr_q + STEP;
                end
            end
            F_HI_REQ: begin
                if (mem_ack) st_d = F_HI_REL;
            end
            F_HI_REL: begin
                if (!mem_ack) begin
                    addr_d = addr_q + STEP;
                    if (idx_q == LAST) begin
                        st_d = F_DONE;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                        st_d  = F_LO_REQ;
                    end
                end
            end
            F_DONE: begin
                if (!fill_req) st_d = F_IDLE;
            end
            default: st_d = F_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= F_IDLE;
            addr_q <= '0;
            idx_q  <= '0;
            lo_q   <= '0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
            idx_q  <= idx_d;
            if (st_q == F_LO_REQ && mem_ack) lo_q <= mem_data;
        end
    end

    // outputs
    always_comb begin
        mem_addr  = addr_q;
        mem_rd    = (st_q == F_LO_REQ) || (st_q == F_HI_REQ);
        fill_done = (st_q == F_DONE);
        filling   = (st_q != F_IDLE) && (st_q != F_DONE);
        wr_en     = (st_q == F_HI_REQ) && mem_ack;
        wr_idx    = idx_q;
        wr_data   = {mem_data[HI_KEEP-1:0], lo_q};
    end

endmodule

// File: rtl/hfb_store.sv
module hfb_store #(
    parameter int WORD_W = 20,
    parameter int DEPTH  = 2047,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
        rd_data <= mem[rd_idx];
    end

endmodule

// File: rtl/hfb_player.sv
module hfb_player
    import hfb_pkg::*;
#(
    parameter int DEPTH = 2047,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             filling,
    input  logic             fill_done,
    input  logic             rd_step,
    input  logic             rd_rewind,
    output logic [IDX_W-1:0] idx_next,
    output logic             rd_valid,
    output logic             rd_final
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    play_state_t      st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (st_q)
            R_EMPTY: if (filling) st_d = R_FILL;
            R_FILL:  if (fill_done) st_d = R_SERVE;
            R_SERVE: if (filling) st_d = R_FILL;
            default: st_d = R_EMPTY;
        endcase
        if (filling || st_q != R_SERVE) begin
            idx_d = '0;
        end else if (rd_rewind) begin
            idx_d = '0;
        end else if (rd_step && idx_q != LAST) begin
            idx_d = idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= R_EMPTY;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    always_comb begin
        idx_next = idx_d;
        rd_valid = (st_q == R_SERVE) && !filling;
        rd_final = rd_valid && (idx_q == LAST);
    end

endmodule

// File: rtl/halfword_fill_buffer.sv
module halfword_fill_buffer #(
    parameter int ADDR_W = 32,
    parameter int HALF_W = 16,
    parameter int WORD_W = 20,
    parameter int DEPTH  = 2047
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_req,
    input  logic [ADDR_W-1:0] fill_base,
    output logic              fill_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic              mem_ack,
    input  logic [HALF_W-1:0] mem_data,
    input  logic              rd_step,
    input  logic              rd_rewind,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_final
);

    localparam int IDX_W = $clog2(DEPTH);

    logic              filling;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_data;
    logic [IDX_W-1:0]  idx_next;

    hfb_fill_ctrl #(
        .ADDR_W(ADDR_W), .HALF_W(HALF_W), .WORD_W(WORD_W),
        .DEPTH(DEPTH), .IDX_W(IDX_W)
    ) u_fill (
        .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_base(fill_base),
        .mem_ack(mem_ack), .mem_data(mem_data), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .fill_done(fill_done), .filling(filling),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    hfb_store #(
        .WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(idx_next), .rd_data(rd_data)
    );

    hfb_player #(
        .DEPTH(DEPTH), .IDX_W(IDX_W)
    ) u_play (
        .clk(clk), .rst_n(rst_n), .filling(filling), .fill_done(fill_done),
        .rd_step(rd_step), .rd_rewind(rd_rewind), .idx_next(idx_next),
        .rd_valid(rd_valid), .rd_final(rd_final)
    );

endmodule

// File: rtl/hfb_checker.sv
module hfb_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fill_req,
    input logic              fill_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_ack,
    input logic              rd_step,
    input logic              rd_rewind,
    input logic              rd_valid,
    input logic              rd_final
);

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && $past(mem_rd) |-> $stable(mem_addr)); // R2

    AST_HOLD_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_ack |=> mem_rd); // R3

    AST_DROP_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && mem_ack |=> !mem_rd); // R3

    AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> !mem_ack); // R3

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done && fill_req |=> fill_done); // R5

    AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done && !fill_req |=> !fill_done); // R5

    AST_QUIET_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !rd_valid); // R6

    AST_FINAL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_final |-> rd_valid); // R8

    AST_FINAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_final && rd_step && !rd_rewind && !fill_req |=> rd_final); // R8

    AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !mem_addr[0]); // R10

endmodule

bind halfword_fill_buffer hfb_checker #(.ADDR_W(ADDR_W)) u_hfb_checker (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_done(fill_done),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_ack(mem_ack),
    .rd_step(rd_step), .rd_rewind(rd_rewind), .rd_valid(rd_valid),
    .rd_final(rd_final)
);

// File: tb/halfword_fill_buffer_test.sv
`timescale 1ns/1ps
module halfword_fill_buffer_test;

    localparam int DEPTH = 4;
    localparam int LAT   = 3;
    localparam int NV    = 8;
    // op: 0 none, 1 step, 2 rewind, 3 step+rewind
    localparam int OPS [NV] = '{0, 1, 1, 1, 1, 2, 3, 1};
    localparam int EXP [NV] = '{0, 1, 2, 3, 3, 0, 0, 1};

    logic        clk = 0;
    logic        rst_n = 0;
    logic        fill_req = 0;
    logic [31:0] fill_base = 0;
    logic        fill_done;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic        mem_ack = 0;
    logic [15:0] mem_data = 0;
    logic        rd_step = 0;
    logic        rd_rewind = 0;
    logic [19:0] rd_data;
    logic        rd_valid;
    logic        rd_final;

    int nchk = 0, errs = 0, mchk = 0, merrs = 0;
    int lat_cnt = 0, nreads = 0;
    logic [31:0] tb_base = 0;

    always #5 clk = ~clk;

    halfword_fill_buffer #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_base(fill_base),
        .fill_done(fill_done), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_ack(mem_ack), .mem_data(mem_data), .rd_step(rd_step),
        .rd_rewind(rd_rewind), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_final(rd_final)
    );

    function automatic logic [15:0] hw(input logic [31:0] a);
        return (a[15:0] * 16'h9E37) ^ 16'h3C5A;
    endfunction

    function automatic logic [19:0] expw(input logic [31:0] b, input int i);
        logic [15:0] lo, hi;
        lo = hw(b + 32'(4 * i));
        hi = hw(b + 32'(4 * i + 2));
        return {hi[3:0], lo};
    endfunction

    // memory model with latency; checks address order and range (R2, R10)
    always @(posedge clk) begin
        if (!rst_n || !mem_rd) begin
            mem_ack <= 0;
            lat_cnt <= 0;
            if (fill_done) nreads <= 0;
        end else if (!mem_ack) begin
            if (lat_cnt == LAT) begin
                mem_ack  <= 1;
                mem_data <= hw(mem_addr);
                nreads   <= nreads + 1;
                mchk     <= mchk + 1;
                if (mem_addr != tb_base + 32'(2 * nreads) || mem_addr < tb_base ||
                    mem_addr >= tb_base + 32'(4 * DEPTH) || mem_addr[0]) begin
                    merrs <= merrs + 1;
                    $display("FAIL R2/R10 address actual=%0h expected=%0h",
                             mem_addr, tb_base + 32'(2 * nreads));
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [31:0] b, input bit poke);
        int  n = 0;
        bit  seen = 0;
        tb_base   = b & ~32'h3;
        fill_base = b;
        fill_req  = 1;
        @(negedge clk);
        while (!fill_done && n < 3000) begin
            if (rd_valid) seen = 1;
            if (poke) begin
                rd_step   = ~rd_step;
                rd_rewind = n[2];
            end
            @(negedge clk);
            n++;
        end
        rd_step   = 0;
        rd_rewind = 0;
        chk(fill_done, "R5 done rises", 32'(fill_done), 1);
        chk(!seen, "R6 valid low during reload", 32'(seen), 0);
        repeat (3) @(negedge clk);
        chk(fill_done, "R5 done holds", 32'(fill_done), 1);
        fill_req = 0;
        @(negedge clk);
        chk(!fill_done, "R5 done falls", 32'(fill_done), 0);
        chk(rd_valid, "R7 valid after reload", 32'(rd_valid), 1);
        chk(rd_data == expw(tb_base, 0), "R7/R4 word 0", 32'(rd_data),
            32'(expw(tb_base, 0)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!mem_rd, "R1 mem_rd", 32'(mem_rd), 0);
        chk(!fill_done, "R1 fill_done", 32'(fill_done), 0);
        chk(!rd_valid, "R1 rd_valid", 32'(rd_valid), 0);
        chk(!rd_final, "R1 rd_final", 32'(rd_final), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!rd_valid, "R1 empty after reset", 32'(rd_valid), 0);

        do_fill(32'h0000_1234, 0);
        chk(nreads == 0, "R2 read count reset", 32'(nreads), 0);

        // vector table walk: R4 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            rd_step   = OPS[v][0];
            rd_rewind = OPS[v][1];
            @(negedge clk);
            rd_step   = 0;
            rd_rewind = 0;
            chk(rd_data == expw(tb_base, EXP[v]), "R4/R7/R9 data", 32'(rd_data),
                32'(expw(tb_base, EXP[v])));
            chk(rd_final == (EXP[v] == DEPTH - 1), "R8 final flag",
                32'(rd_final), 32'(EXP[v] == DEPTH - 1));
            chk(rd_valid, "R7 valid", 32'(rd_valid), 1);
        end

        // second reload, unaligned base, pulses during reload ignored (R6, R2)
        do_fill(32'h0000_0203, 1);
        rd_step = 1;
        @(negedge clk);
        rd_step = 0;
        chk(rd_data == expw(32'h200, 1), "R7 step after reload", 32'(rd_data),
            32'(expw(32'h200, 1)));

        chk(mchk == 4 * DEPTH, "R2 halfword reads", 32'(mchk), 32'(4 * DEPTH));
        $display("Result: errors=%0d of %0d checks", errs + merrs, nchk + mchk);
        $finish;
    end

    initial begin
        #2000000;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs + merrs + 1, nchk + mchk + 1);
        $finish;
    end

endmodule